// File: doc/BRIEF.md
# Banked Logical-to-Physical Address Translator

This block widens the 16-bit logical addresses of an 8-bit processor into 20-bit physical addresses. The logical space is cut into up to three regions by two 4-bit page boundaries held together in one 8-bit boundary register. The regions are a low common region, a middle banked region and an upper common region. The banked region and the upper common region each take an 8-bit base value, in 4 KB units, which is added to the logical address. The low common region passes through without any offset.

The processor reaches the three 8-bit registers through a small I/O port interface. It has a port address, write data, a write strobe and a read strobe. A read returns the register contents. Translation is purely combinational from the present logical address and register state. After reset the mapping is the identity, so software that never touches the registers sees a flat 64 KB space.

Top module: `banked_addr_xlate`

## Requirements
- R1: After reset the boundary register (port PORT_BASE+0) reads 0xF0, and the bank base register (PORT_BASE+1) and the common base register (PORT_BASE+2) read 0x00.
- R2: With the reset register values the mapping is the identity: logical 0x1000 gives 0x01000 and logical 0xF800 gives 0x0F800.
- R3: A write strobe to a register port changes that register at the next rising clock edge. A following read of that port returns the written byte.
- R4: A logical address whose bits 15:12 are greater than or equal to the boundary register's high nibble maps to logical + common base × 4096.
- R5: A logical address whose bits 15:12 are below the high nibble but at or above the low nibble maps to logical + bank base × 4096.
- R6: A logical address whose bits 15:12 are below both nibbles maps to itself, with physical bits 19:16 zero.
- R7: The 20-bit sum wraps modulo 2^20. For example, common base 0xFF with logical 0xF000 in the upper region gives 0x0E000.
- R8: With a boundary of 0x00 the whole logical space uses the common base.
- R9: When the high nibble is below the low nibble, the high-nibble comparison still wins. Pages at or above it use the common base, and pages below it pass through unchanged.
- R10: A read of any port other than the three register ports returns 0x00 with the select output low. A write to such a port changes no register.
- R11: The select output is high exactly when the read strobe is high and the port address is one of the three register ports. The read data is 0x00 whenever select is low.
- R12: Physical bits 11:0 always equal logical bits 11:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for register writes |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 8 | I/O port address |
| io_wdata | input | 8 | Write data byte |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data byte, zero when not selected |
| io_sel | output | 1 | High when a read hits a register port |
| log_addr | input | 16 | Logical address from the processor |
| phys_addr | output | 20 | Translated physical address |

## Verification
The translation is first tried at the reset values, where any offset leak shows up as a departure from the identity. It is then tried with three different region layouts: all three regions present, the low and upper common regions only, and the banked and upper regions only. The bank and common bases are given distinct values, so each physical result shows which region was chosen. Addresses on both sides of each boundary page separate an off-by-one comparison from a correct one. A large common base at the top page exercises the modulo wrap. An inverted boundary pair shows which comparison takes precedence. Unmapped reads and writes are followed by readback of all three registers.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
   typedef enum logic [1:0] {
      AREA_LOW  = 2'd0,
      AREA_BANK = 2'd1,
      AREA_HIGH = 2'd2
   } area_e;

   localparam int NUM_REGS  = 3;
   localparam int IDX_BOUND = 0;
   localparam int IDX_BANK  = 1;
   localparam int IDX_COM   = 2;
endpackage

// File: rtl/xlate_regs.sv
module xlate_regs
   import xlate_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int PORT_W = 8,
   parameter logic [PORT_W-1:0] PORT_BASE = 8'h38,
   parameter logic [DATA_W-1:0] BOUND_RST = 8'hF0,
   parameter logic [DATA_W-1:0] BANK_RST  = 8'h00,
   parameter logic [DATA_W-1:0] COM_RST   = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PORT_W-1:0] io_addr,
   input  logic [DATA_W-1:0] io_wdata,
   input  logic              io_wr,
   input  logic              io_rd,
   output logic [DATA_W-1:0] io_rdata,
   output logic              io_sel,
   output logic [DATA_W-1:0] bound_q,
   output logic [DATA_W-1:0] bank_q,
   output logic [DATA_W-1:0] com_q
);
   localparam logic [DATA_W-1:0] RST_VAL [NUM_REGS] = '{BOUND_RST, BANK_RST, COM_RST};

   logic [PORT_W-1:0] idx;
   logic              hit;
   logic [DATA_W-1:0] regs_q [NUM_REGS];

   assign idx = io_addr - PORT_BASE;
   assign hit = (idx < PORT_W'(NUM_REGS));

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)
            regs_q[i] <= RST_VAL[i];
         else if (io_wr && (idx == PORT_W'(i)))
            regs_q[i] <= io_wdata;
      end
   end

   always_comb begin
      io_rdata = '0;
      for (int i = 0; i < NUM_REGS; i++)
         if (io_rd && (idx == PORT_W'(i)))
            io_rdata = regs_q[i];
   end

   assign io_sel  = io_rd && hit;
   assign bound_q = regs_q[IDX_BOUND];
   assign bank_q  = regs_q[IDX_BANK];
   assign com_q   = regs_q[IDX_COM];
endmodule

// File: rtl/xlate_area_decode.sv
module xlate_area_decode
   import xlate_pkg::*;
#(
   parameter int PAGE_W = 4
) (
   input  logic [PAGE_W-1:0] page,
   input  logic [PAGE_W-1:0] high_start,
   input  logic [PAGE_W-1:0] bank_start,
   output area_e             area
);
   always_comb begin
      if (page >= high_start)
         area = AREA_HIGH;
      else if (page >= bank_start)
         area = AREA_BANK;
      else
         area = AREA_LOW;
   end
endmodule

// File: rtl/xlate_offset_add.sv
module xlate_offset_add #(
   parameter int LA_W   = 16,
   parameter int PA_W   = 20,
   parameter int BASE_W = 8
) (
   input  logic [LA_W-1:0]   log_addr,
   input  logic [BASE_W-1:0] base,
   output logic [PA_W-1:0]   phys_addr
);
   localparam int OFF_W = PA_W - BASE_W;

   logic [PA_W-1:0] la_ext;
   logic [PA_W-1:0] base_ext;

   assign la_ext    = {{(PA_W-LA_W){1'b0}}, log_addr};
   assign base_ext  = {base, {OFF_W{1'b0}}};
   assign phys_addr = la_ext + base_ext;
endmodule

// File: rtl/banked_addr_xlate.sv
module banked_addr_xlate
   import xlate_pkg::*;
#(
   parameter int LA_W   = 16,
   parameter int PA_W   = 20,
   parameter int PAGE_W = 4,
   parameter int DATA_W = 8,
   parameter int PORT_W = 8,
   parameter logic [PORT_W-1:0] PORT_BASE = 8'h38,
   parameter logic [DATA_W-1:0] BOUND_RST = 8'hF0,
   parameter logic [DATA_W-1:0] BANK_RST  = 8'h00,
   parameter logic [DATA_W-1:0] COM_RST   = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PORT_W-1:0] io_addr,
   input  logic [DATA_W-1:0] io_wdata,
   input  logic              io_wr,
   input  logic              io_rd,
   output logic [DATA_W-1:0] io_rdata,
   output logic              io_sel,
   input  logic [LA_W-1:0]   log_addr,
   output logic [PA_W-1:0]   phys_addr
);
   localparam int OFF_W  = LA_W - PAGE_W;
   localparam int BASE_W = PA_W - OFF_W;

   if (DATA_W != 2 * PAGE_W) begin : g_bad_bound
      $fatal(1, "boundary register must hold two page numbers");
   end
   if (BASE_W > DATA_W || BASE_W < 1) begin : g_bad_base
      $fatal(1, "base register too narrow for physical width");
   end
   if (PA_W <= LA_W) begin : g_bad_widths
      $fatal(1, "physical width must exceed logical width");
   end

   logic [DATA_W-1:0] bound_q, bank_q, com_q;
   logic [BASE_W-1:0] sel_base;
   area_e             area;

   xlate_regs #(
      .DATA_W(DATA_W), .PORT_W(PORT_W), .PORT_BASE(PORT_BASE),
      .BOUND_RST(BOUND_RST), .BANK_RST(BANK_RST), .COM_RST(COM_RST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
      .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .io_sel(io_sel),
      .bound_q(bound_q), .bank_q(bank_q), .com_q(com_q)
   );

   xlate_area_decode #(.PAGE_W(PAGE_W)) u_decode (
      .page      (log_addr[LA_W-1:OFF_W]),
      .high_start(bound_q[DATA_W-1:PAGE_W]),
      .bank_start(bound_q[PAGE_W-1:0]),
      .area      (area)
   );

   always_comb begin
      unique case (area)
         AREA_HIGH: sel_base = com_q[BASE_W-1:0];
         AREA_BANK: sel_base = bank_q[BASE_W-1:0];
         default:   sel_base = '0;
      endcase
   end

   xlate_offset_add #(.LA_W(LA_W), .PA_W(PA_W), .BASE_W(BASE_W)) u_add (
      .log_addr (log_addr),
      .base     (sel_base),
      .phys_addr(phys_addr)
   );
endmodule

// File: rtl/banked_addr_xlate_chk.sv
module banked_addr_xlate_chk #(
   parameter int LA_W   = 16,
   parameter int PA_W   = 20,
   parameter int PAGE_W = 4,
   parameter int DATA_W = 8,
   parameter int PORT_W = 8,
   parameter logic [PORT_W-1:0] PORT_BASE = 8'h38
) (
   input logic              clk,
   input logic              rst_n,
   input logic [PORT_W-1:0] io_addr,
   input logic [DATA_W-1:0] io_wdata,
   input logic              io_wr,
   input logic              io_rd,
   input logic [DATA_W-1:0] io_rdata,
   input logic              io_sel,
   input logic [LA_W-1:0]   log_addr,
   input logic [PA_W-1:0]   phys_addr,
   input logic [DATA_W-1:0] bound_q
);
   localparam int OFF_W = LA_W - PAGE_W;
   localparam logic [PORT_W-1:0] BANK_PORT = PORT_BASE + PORT_W'(1);

   logic [PORT_W-1:0] rel;
   logic              mapped;
   logic [PAGE_W-1:0] pg;

   assign rel    = io_addr - PORT_BASE;
   assign mapped = (rel < PORT_W'(3));
   assign pg     = log_addr[LA_W-1:OFF_W];

   assert_write_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(io_wr && io_addr == BANK_PORT) && io_rd && io_addr == BANK_PORT)
      |-> io_rdata == $past(io_wdata));

   assert_unmapped_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && !mapped) |-> (io_rdata == '0 && !io_sel));

   assert_sel_needs_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
      io_sel |-> io_rd);

   assert_quiet_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !io_sel |-> io_rdata == '0);

   assert_page_offset_R12: assert property (@(posedge clk) disable iff (!rst_n)
      phys_addr[OFF_W-1:0] == log_addr[OFF_W-1:0]);

   assert_low_region_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pg < bound_q[PAGE_W-1:0] && pg < bound_q[DATA_W-1:PAGE_W])
      |-> phys_addr == {{(PA_W-LA_W){1'b0}}, log_addr});
endmodule

bind banked_addr_xlate banked_addr_xlate_chk #(
   .LA_W(LA_W), .PA_W(PA_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W),
   .PORT_W(PORT_W), .PORT_BASE(PORT_BASE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
   .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .io_sel(io_sel),
   .log_addr(log_addr), .phys_addr(phys_addr), .bound_q(bound_q)
);

// File: tb/banked_addr_xlate_test.sv
`timescale 1ns/1ps
module banked_addr_xlate_test;
   localparam logic [7:0] PB = 8'h38;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  io_addr = 8'h00;
   logic [7:0]  io_wdata = 8'h00;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic [7:0]  io_rdata;
   logic        io_sel;
   logic [15:0] log_addr = 16'h0000;
   logic [19:0] phys_addr;

   int  checks = 0;
   int  fails = 0;
   bit  done = 0;
   int  mreg [3];

   always #2.5 clk = ~clk;

   banked_addr_xlate uut (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
      .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .io_sel(io_sel),
      .log_addr(log_addr), .phys_addr(phys_addr)
   );

   // behavioural reference: register contents tracked at each edge
   always @(posedge clk) begin
      if (!rst_n) begin
         mreg[0] <= 'hF0; mreg[1] <= 0; mreg[2] <= 0;
      end else if (io_wr && int'(io_addr) >= int'(PB) && int'(io_addr) < int'(PB) + 3) begin
         mreg[int'(io_addr) - int'(PB)] <= int'(io_wdata);
      end
   end

   function automatic int ref_phys(int la, int bnd, int bk, int cm);
      int pg = la / 4096;
      if (pg >= bnd / 16) return (la + cm * 4096) % 1048576;
      if (pg >= bnd % 16) return (la + bk * 4096) % 1048576;
      return la;
   endfunction

   function automatic int ref_rdata(int a, bit rd);
      if (rd && a >= int'(PB) && a < int'(PB) + 3) return mreg[a - int'(PB)];
      return 0;
   endfunction

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // compared on every clock against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R4/R5/R6 per-cycle phys", int'(phys_addr),
             ref_phys(int'(log_addr), mreg[0], mreg[1], mreg[2]));
         chk("R11 per-cycle rdata", int'(io_rdata), ref_rdata(int'(io_addr), io_rd));
         chk("R11 per-cycle sel", int'(io_sel),
             int'(io_rd && int'(io_addr) >= int'(PB) && int'(io_addr) < int'(PB) + 3));
      end
   end

   task automatic wr(logic [7:0] a, logic [7:0] d);
      @(posedge clk); #1;
      io_addr = a; io_wdata = d; io_wr = 1'b1; io_rd = 1'b0;
      @(posedge clk); #1;
      io_wr = 1'b0;
   endtask

   task automatic rd_chk(string tag, logic [7:0] a, int exp, int exp_sel);
      @(posedge clk); #1;
      io_addr = a; io_rd = 1'b1;
      @(negedge clk);
      chk(tag, int'(io_rdata), exp);
      chk(tag, int'(io_sel), exp_sel);
      @(posedge clk); #1;
      io_rd = 1'b0;
   endtask

   task automatic tr_chk(string tag, logic [15:0] la, int exp);
      @(posedge clk); #1;
      log_addr = la;
      @(negedge clk);
      chk(tag, int'(phys_addr), exp);
   endtask

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset values
      rd_chk("R1 boundary reset", PB, 'hF0, 1);
      rd_chk("R1 bank reset", PB + 8'd1, 'h00, 1);
      rd_chk("R1 common reset", PB + 8'd2, 'h00, 1);
      // R2 identity
      tr_chk("R2 identity 0x1000", 16'h1000, 'h01000);
      tr_chk("R2 identity 0xF800", 16'hF800, 'h0F800);
      // R3 write lands next edge
      wr(PB + 8'd1, 8'h12);
      wr(PB + 8'd2, 8'h40);
      wr(PB, 8'hA8);
      rd_chk("R3 bank readback", PB + 8'd1, 'h12, 1);
      rd_chk("R3 common readback", PB + 8'd2, 'h40, 1);
      rd_chk("R3 boundary readback", PB, 'hA8, 1);
      // three regions, CA=A BA=8
      tr_chk("R4 upper region", 16'hB123, 'h4B123);
      tr_chk("R4 upper first page", 16'hA000, 'h4A000);
      tr_chk("R5 bank region", 16'h9456, 'h1B456);
      tr_chk("R5 bank last byte", 16'h9FFF, 'h1BFFF);
      tr_chk("R5 bank first page", 16'h8000, 'h1A000);
      tr_chk("R6 low region", 16'h7ABC, 'h07ABC);
      tr_chk("R6 low last byte", 16'h7FFF, 'h07FFF);
      tr_chk("R12 offset pass", 16'hB5A5, 'h4B5A5);
      // R7 wrap
      wr(PB + 8'd2, 8'hFF);
      tr_chk("R7 wrap top", 16'hF000, 'h0E000);
      tr_chk("R7 wrap end", 16'hFFFF, 'h0EFFF);
      // R8 whole space upper
      wr(PB, 8'h00);
      tr_chk("R8 all upper 0x0123", 16'h0123, 'hFF123);
      tr_chk("R8 all upper 0x0000", 16'h0000, 'hFF000);
      // two low/high regions
      wr(PB + 8'd2, 8'h20);
      wr(PB, 8'h55);
      tr_chk("R6 low only 0x4FFF", 16'h4FFF, 'h04FFF);
      tr_chk("R4 high after low 0x5000", 16'h5000, 'h25000);
      // bank and upper only
      wr(PB, 8'h60);
      tr_chk("R5 bank from zero 0x0000", 16'h0000, 'h12000);
      tr_chk("R4 high 0x6000", 16'h6000, 'h26000);
      // R9 inverted boundary, high nibble below low nibble
      wr(PB + 8'd2, 8'hFF);
      wr(PB, 8'h38);
      tr_chk("R9 precedence upper 0x5000", 16'h5000, 'h04000);
      tr_chk("R9 precedence low 0x1000", 16'h1000, 'h01000);
      // R10 unmapped port access
      rd_chk("R10 unmapped read below", PB - 8'd1, 0, 0);
      rd_chk("R10 unmapped read above", PB + 8'd3, 0, 0);
      wr(PB + 8'd3, 8'h77);
      wr(PB - 8'd1, 8'h66);
      rd_chk("R10 boundary untouched", PB, 'h38, 1);
      rd_chk("R10 bank untouched", PB + 8'd1, 'h12, 1);
      rd_chk("R10 common untouched", PB + 8'd2, 'hFF, 1);
      // R11 no read strobe means no select
      @(posedge clk); #1;
      io_addr = PB; io_rd = 1'b0;
      @(negedge clk);
      chk("R11 idle rdata", int'(io_rdata), 0);
      chk("R11 idle sel", int'(io_sel), 0);
      // R1 reset again restores values
      @(posedge clk); #1 rst_n = 1'b0;
      @(posedge clk); #1 rst_n = 1'b1;
      rd_chk("R1 boundary after reset", PB, 'hF0, 1);
      tr_chk("R2 identity after reset", 16'hF800, 'h0F800);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule